// File: doc/BRIEF.md
# PWM Fault Brake Combiner

This block sits between a six-channel PWM generator and the output pins. It collects fault indications from several places: two analog comparator outputs, two external brake pins, a chip-health fail signal and software triggers. From these it forms two brake requests. The edge brake catches the rising edge of any enabled source and holds it in a sticky flag until software clears the flag. The level brake follows its enabled sources and drops as soon as they are all quiet. Each source has one enable bit for the edge path and a separate enable bit for the level path, so the same fault can latch, follow, or do both.

While either brake is active, every channel is driven to its inactive level. A per-channel polarity bit then sets what the active and inactive levels are on the pin. External brake pins go through a two-flop synchronizer and a programmable glitch filter first. The system-fail source is the OR of clock-fail, brown-out and core-lockup inputs, each with its own gate. Software reaches the settings through a small register port with a single-cycle write strobe and a combinational read.

Register addresses: 0 brake control, 1 software trigger, 2 fail enable, 3 polarity (bits 5:0), 4 filter length (bits 2:0), 5 status (bit 0 edge flag, bit 1 level brake).

Top module: `pwm_brake_combiner`

## Requirements
- R1: Brake control register (address 0) bits are the edge-path enables: bit 0 comparator 0, bit 1 comparator 1, bit 4 brake pin 0, bit 5 brake pin 1, bit 7 system fail. The register reads back what was written.
- R2: The level-path enables sit in the same register: bit 8 comparator 0, bit 9 comparator 1, bit 12 brake pin 0, bit 13 brake pin 1, bit 15 system fail.
- R3: A rising edge on any edge-enabled source sets the edge flag (status bit 0) on the next clock. The flag stays set after the source falls, and clears only when 1 is written to status bit 0 at address 5. A set in the same cycle wins over a clear.
- R4: The level brake (status bit 1) is high in the cycle after any level-enabled source is high. It drops in the first cycle after all of them are low.
- R5: Writing 1 to bit 0 of address 1 gives a one-cycle edge trigger. Writing 1 to bit 8 gives a one-cycle level trigger, which makes the level brake high for exactly one cycle. Both triggers bypass the enables, and address 1 always reads 0.
- R6: System fail is the OR of clock fail gated by bit 0, brown-out gated by bit 1, and core lockup gated by bit 3 of the fail enable register (address 2). A condition whose bit is 0 has no effect.
- R7: Each brake pin passes through two synchronizing flops. It then changes its filtered level only after the new level has been seen for N consecutive clocks, where N is the filter field (address 4, bits 2:0) plus 1. Shorter pulses are dropped.
- R8: With no brake, each channel output equals its PWM input XOR its polarity bit (address 3, bit i for channel i). A polarity bit of 0 therefore means active high.
- R9: While either brake is active, each channel output equals its polarity bit: the inactive level 0, then inverted.
- R10: After reset all registers and both brakes are 0, and the outputs pass the PWM inputs unchanged.
- R11: A source whose enable bit is 0 on a path does not affect that path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| cmp_out | input | 2 | Comparator outputs, synchronous |
| brk_pin | input | 2 | External brake pins, asynchronous |
| clk_fail | input | 1 | Clock-fail condition |
| bod_det | input | 1 | Brown-out condition |
| lockup | input | 1 | Core-lockup condition |
| pwm_in | input | 6 | Raw PWM channel levels |
| pwm_out | output | 6 | Channel outputs after brake and polarity |
| brake_edge | output | 1 | Sticky edge brake flag |
| brake_level | output | 1 | Level brake state |

## Verification
The assertions assume that the comparator and health inputs are already synchronous to clk and change only between edges. They also assume reset is held for at least one edge before any input is checked. The bench meets both by driving every input on the falling edge after reset has been released. The brake pins are the only inputs treated as asynchronous. They are exercised both with pulses shorter than the filter length and with levels held well beyond it, so the filter decision never falls on a boundary sample.

// File: rtl/pwm_brake_pkg.sv
package pwm_brake_pkg;

    localparam int NUM_CH   = 6;
    localparam int NUM_CMP  = 2;
    localparam int NUM_PIN  = 2;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 3;
    localparam int FLT_W    = 3;
    localparam int FAIL_W   = 4;
    localparam int SRC_W    = NUM_CMP + NUM_PIN + 1;
    localparam int LVL_OFS  = 8;

    // bit positions of the edge-path enables; level path adds LVL_OFS
    localparam int EN_CMP0  = 0;
    localparam int EN_PIN0  = 4;
    localparam int EN_SYS   = 7;

    localparam int SW_EDGE_BIT = 0;
    localparam int SW_LVL_BIT  = 8;

    localparam int FAIL_CLK = 0;
    localparam int FAIL_BOD = 1;
    localparam int FAIL_LCK = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADR_CTL  = 3'd0,
        ADR_SWT  = 3'd1,
        ADR_FAIL = 3'd2,
        ADR_POL  = 3'd3,
        ADR_FLT  = 3'd4,
        ADR_STAT = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic               sys;
        logic [NUM_PIN-1:0] pin;
        logic [NUM_CMP-1:0] cmp;
    } brk_src_t;

    function automatic brk_src_t pick_enables(input logic [DATA_W-1:0] ctl, input int base);
        brk_src_t e;
        for (int i = 0; i < NUM_CMP; i++) e.cmp[i] = ctl[base + EN_CMP0 + i];
        for (int i = 0; i < NUM_PIN; i++) e.pin[i] = ctl[base + EN_PIN0 + i];
        e.sys = ctl[base + EN_SYS];
        return e;
    endfunction

    function automatic logic combine_fail(input logic [FAIL_W-1:0] en,
                                          input logic cf, input logic bd, input logic lk);
        return (en[FAIL_CLK] & cf) | (en[FAIL_BOD] & bd) | (en[FAIL_LCK] & lk);
    endfunction

endpackage

// File: rtl/brake_pin_filter.sv
module brake_pin_filter #(
    parameter int FLT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_raw,
    input  logic [FLT_W-1:0] run_len,
    output logic             pin_clean
);
    logic             sync_a;
    logic             sync_b;
    logic             stable_q;
    logic [FLT_W-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_a   <= 1'b0;
            sync_b   <= 1'b0;
            stable_q <= 1'b0;
            run_cnt  <= '0;
        end else begin
            sync_a <= pin_raw;
            sync_b <= sync_a;
            if (sync_b != stable_q) begin
                if (run_cnt == run_len) begin
                    stable_q <= sync_b;
                    run_cnt  <= '0;
                end else begin
                    run_cnt <= run_cnt + 1'b1;
                end
            end else begin
                run_cnt <= '0;
            end
        end
    end

    assign pin_clean = stable_q;
endmodule

// File: rtl/brake_arbiter.sv
module brake_arbiter
    import pwm_brake_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  brk_src_t src,
    input  brk_src_t edge_en,
    input  brk_src_t lvl_en,
    input  logic     sw_edge,
    input  logic     sw_lvl,
    input  logic     clr_edge,
    output logic     edge_flag,
    output logic     lvl_state,
    output logic     lvl_any
);
    logic [SRC_W-1:0] cur;
    logic [SRC_W-1:0] prev_q;
    logic             edge_hit;

    assign cur      = src;
    assign edge_hit = (|(cur & ~prev_q & edge_en)) | sw_edge;
    assign lvl_any  = (|(cur & lvl_en)) | sw_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q    <= '0;
            edge_flag <= 1'b0;
            lvl_state <= 1'b0;
        end else begin
            prev_q    <= cur;
            lvl_state <= lvl_any;
            if (edge_hit)      edge_flag <= 1'b1;
            else if (clr_edge) edge_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/pwm_polarity_stage.sv
module pwm_polarity_stage #(
    parameter int NUM_CH = 6
) (
    input  logic [NUM_CH-1:0] pwm_in,
    input  logic [NUM_CH-1:0] inv,
    input  logic              brake,
    output logic [NUM_CH-1:0] pwm_out
);
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        assign pwm_out[ch] = (brake ? 1'b0 : pwm_in[ch]) ^ inv[ch];
    end
endmodule

// File: rtl/pwm_brake_combiner.sv
module pwm_brake_combiner
    import pwm_brake_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NUM_CMP-1:0] cmp_out,
    input  logic [NUM_PIN-1:0] brk_pin,
    input  logic              clk_fail,
    input  logic              bod_det,
    input  logic              lockup,
    input  logic [NUM_CH-1:0] pwm_in,
    output logic [NUM_CH-1:0] pwm_out,
    output logic              brake_edge,
    output logic              brake_level
);
    logic [DATA_W-1:0]  ctl_q;
    logic [FAIL_W-1:0]  fail_q;
    logic [NUM_CH-1:0]  pol_q;
    logic [FLT_W-1:0]   flt_q;
    logic               sw_edge_q;
    logic               sw_lvl_q;
    logic               clr_edge;
    logic               lvl_any;
    logic [NUM_PIN-1:0] pin_clean;
    brk_src_t           src;
    brk_src_t           edge_en;
    brk_src_t           lvl_en;

    function automatic logic wr_hit(input logic we, input logic [ADDR_W-1:0] a, input reg_addr_e t);
        return we && (a == t);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q     <= '0;
            fail_q    <= '0;
            pol_q     <= '0;
            flt_q     <= '0;
            sw_edge_q <= 1'b0;
            sw_lvl_q  <= 1'b0;
        end else begin
            if (wr_hit(reg_wr, reg_addr, ADR_CTL))  ctl_q  <= reg_wdata;
            if (wr_hit(reg_wr, reg_addr, ADR_FAIL)) fail_q <= reg_wdata[FAIL_W-1:0];
            if (wr_hit(reg_wr, reg_addr, ADR_POL))  pol_q  <= reg_wdata[NUM_CH-1:0];
            if (wr_hit(reg_wr, reg_addr, ADR_FLT))  flt_q  <= reg_wdata[FLT_W-1:0];
            sw_edge_q <= wr_hit(reg_wr, reg_addr, ADR_SWT) && reg_wdata[SW_EDGE_BIT];
            sw_lvl_q  <= wr_hit(reg_wr, reg_addr, ADR_SWT) && reg_wdata[SW_LVL_BIT];
        end
    end

    assign clr_edge = wr_hit(reg_wr, reg_addr, ADR_STAT) && reg_wdata[0];

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADR_CTL:  reg_rdata = ctl_q;
            ADR_FAIL: reg_rdata[FAIL_W-1:0] = fail_q;
            ADR_POL:  reg_rdata[NUM_CH-1:0] = pol_q;
            ADR_FLT:  reg_rdata[FLT_W-1:0]  = flt_q;
            ADR_STAT: reg_rdata[1:0] = {brake_level, brake_edge};
            default:  reg_rdata = '0;
        endcase
    end

    for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
        brake_pin_filter #(.FLT_W(FLT_W)) flt_i (
            .clk       (clk),
            .rst       (rst),
            .pin_raw   (brk_pin[p]),
            .run_len   (flt_q),
            .pin_clean (pin_clean[p])
        );
    end

    always_comb begin
        src.cmp = cmp_out;
        src.pin = pin_clean;
        src.sys = combine_fail(fail_q, clk_fail, bod_det, lockup);
        edge_en = pick_enables(ctl_q, 0);
        lvl_en  = pick_enables(ctl_q, LVL_OFS);
    end

    brake_arbiter arb_i (
        .clk       (clk),
        .rst       (rst),
        .src       (src),
        .edge_en   (edge_en),
        .lvl_en    (lvl_en),
        .sw_edge   (sw_edge_q),
        .sw_lvl    (sw_lvl_q),
        .clr_edge  (clr_edge),
        .edge_flag (brake_edge),
        .lvl_state (brake_level),
        .lvl_any   (lvl_any)
    );

    pwm_polarity_stage #(.NUM_CH(NUM_CH)) out_i (
        .pwm_in  (pwm_in),
        .inv     (pol_q),
        .brake   (brake_edge | brake_level),
        .pwm_out (pwm_out)
    );
endmodule

// File: rtl/pwm_brake_checker.sv
module pwm_brake_checker
    import pwm_brake_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [NUM_CH-1:0] pwm_out,
    input logic [NUM_CH-1:0] pol_q,
    input logic              brake_edge,
    input logic              brake_level,
    input logic              clr_edge,
    input logic              lvl_any
);
    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (brake_edge && !clr_edge) |=> brake_edge);                           // R3
    AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        lvl_any |=> brake_level);                                            // R4
    AST_LEVEL_RELEASE: assert property (@(posedge clk) disable iff (rst)
        !lvl_any |=> !brake_level);                                          // R4
    AST_SWT_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADR_SWT) |-> (reg_rdata == '0));                        // R5
    AST_BRAKE_INACTIVE: assert property (@(posedge clk) disable iff (rst)
        (brake_edge || brake_level) |-> (pwm_out == pol_q));                 // R9
endmodule

bind pwm_brake_combiner pwm_brake_checker chk_i (
    .clk         (clk),
    .rst         (rst),
    .reg_addr    (reg_addr),
    .reg_rdata   (reg_rdata),
    .pwm_out     (pwm_out),
    .pol_q       (pol_q),
    .brake_edge  (brake_edge),
    .brake_level (brake_level),
    .clr_edge    (clr_edge),
    .lvl_any     (lvl_any)
);

// File: tb/pwm_brake_combiner_tb.sv
`timescale 1ns/1ps
module pwm_brake_combiner_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [1:0]  cmp_out = '0;
    logic [1:0]  brk_pin = '0;
    logic        clk_fail = 1'b0;
    logic        bod_det = 1'b0;
    logic        lockup = 1'b0;
    logic [5:0]  pwm_in = '0;
    logic [5:0]  pwm_out;
    logic        brake_edge;
    logic        brake_level;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    pwm_brake_combiner dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmp_out(cmp_out),
        .brk_pin(brk_pin), .clk_fail(clk_fail), .bod_det(bod_det),
        .lockup(lockup), .pwm_in(pwm_in), .pwm_out(pwm_out),
        .brake_edge(brake_edge), .brake_level(brake_level)
    );

    typedef struct packed {
        logic [15:0] ctl;
        logic [5:0]  pol;
        logic [1:0]  cmp;
        logic [5:0]  pwm;
        logic [5:0]  exp_out;
        logic        exp_lvl;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VEC [NVEC] = '{
        '{16'h0000, 6'h00, 2'b11, 6'h2A, 6'h2A, 1'b0},
        '{16'h0100, 6'h00, 2'b01, 6'h2A, 6'h00, 1'b1},
        '{16'h0100, 6'h3F, 2'b01, 6'h2A, 6'h3F, 1'b1},
        '{16'h0200, 6'h0F, 2'b01, 6'h15, 6'h1A, 1'b0},
        '{16'h0200, 6'h0F, 2'b10, 6'h15, 6'h0F, 1'b1},
        '{16'h0300, 6'h30, 2'b00, 6'h3F, 6'h0F, 1'b0}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] rv;
        pwm_in = 6'h15;
        idle(3);
        rst = 1'b0;
        idle(1);
        // R10 reset state
        check("R10 pwm_out", {10'd0, pwm_out}, 16'h0015);
        check("R10 brakes", {14'd0, brake_edge, brake_level}, 16'h0000);
        rd(3'd0, rv);
        check("R10 ctl reset", rv, 16'h0000);

        // R1 R2 readback
        wr(3'd0, 16'hB3B3);
        rd(3'd0, rv);
        check("R1 ctl readback", rv, 16'hB3B3);
        wr(3'd0, 16'h0000);

        // R8 R9 R2 vector table (level path on comparators)
        for (int i = 0; i < NVEC; i++) begin
            wr(3'd0, VEC[i].ctl);
            wr(3'd3, {10'd0, VEC[i].pol});
            cmp_out = VEC[i].cmp;
            pwm_in  = VEC[i].pwm;
            idle(3);
            check("R8/R9 vector pwm_out", {10'd0, pwm_out}, {10'd0, VEC[i].exp_out});
            check("R2 vector level", {15'd0, brake_level}, {15'd0, VEC[i].exp_lvl});
            check("R11 vector edge idle", {15'd0, brake_edge}, 16'h0000);
            cmp_out = '0;
            idle(2);
        end
        wr(3'd3, 16'h0000);
        pwm_in = 6'h2D;

        // R4 exact release
        wr(3'd0, 16'h0100);
        cmp_out = 2'b01;
        idle(1);
        check("R4 level asserts next cycle", {15'd0, brake_level}, 16'h0001);
        cmp_out = 2'b00;
        idle(1);
        check("R4 level releases next cycle", {15'd0, brake_level}, 16'h0000);
        check("R8 pass after release", {10'd0, pwm_out}, 16'h002D);

        // R3 edge sticky and clear
        wr(3'd0, 16'h0001);
        cmp_out = 2'b01;
        idle(2);
        check("R3 edge set", {15'd0, brake_edge}, 16'h0001);
        cmp_out = 2'b00;
        idle(3);
        check("R3 edge sticky", {15'd0, brake_edge}, 16'h0001);
        check("R9 outputs held", {10'd0, pwm_out}, 16'h0000);
        rd(3'd5, rv);
        check("R3 status bit0", rv, 16'h0001);
        wr(3'd5, 16'h0001);
        idle(1);
        check("R3 edge cleared", {15'd0, brake_edge}, 16'h0000);

        // R11 disabled edge source
        cmp_out = 2'b10;
        idle(3);
        check("R11 disabled cmp1 ignored", {15'd0, brake_edge}, 16'h0000);
        cmp_out = 2'b00;
        wr(3'd0, 16'h0000);

        // R5 software triggers
        wr(3'd1, 16'h0001);
        idle(1);
        check("R5 sw edge trigger", {15'd0, brake_edge}, 16'h0001);
        rd(3'd1, rv);
        check("R5 swt reads zero", rv, 16'h0000);
        wr(3'd5, 16'h0001);
        idle(1);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 16'h0100;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
        check("R5 level pulse not yet", {15'd0, brake_level}, 16'h0000);
        @(negedge clk);
        check("R5 level pulse high", {15'd0, brake_level}, 16'h0001);
        @(negedge clk);
        check("R5 level pulse one cycle", {15'd0, brake_level}, 16'h0000);
        check("R5 no edge from level trigger", {15'd0, brake_edge}, 16'h0000);

        // R6 system fail
        wr(3'd0, 16'h8000);
        wr(3'd2, 16'h0002);
        bod_det = 1'b1;
        idle(2);
        check("R6 brown-out gated on", {15'd0, brake_level}, 16'h0001);
        wr(3'd2, 16'h0001);
        idle(2);
        check("R6 brown-out gated off", {15'd0, brake_level}, 16'h0000);
        clk_fail = 1'b1;
        idle(2);
        check("R6 clock fail", {15'd0, brake_level}, 16'h0001);
        clk_fail = 1'b0; bod_det = 1'b0;
        wr(3'd2, 16'h0008);
        lockup = 1'b1;
        idle(2);
        check("R6 lockup", {15'd0, brake_level}, 16'h0001);
        lockup = 1'b0;
        idle(2);
        check("R6 lockup released", {15'd0, brake_level}, 16'h0000);
        wr(3'd2, 16'h0000);

        // R7 pin filter, N = 4
        wr(3'd4, 16'h0003);
        wr(3'd0, 16'h1000);
        brk_pin = 2'b01;
        idle(2);
        brk_pin = 2'b00;
        idle(10);
        check("R7 short pulse dropped", {15'd0, brake_level}, 16'h0000);
        brk_pin = 2'b01;
        idle(12);
        check("R7 held level accepted", {15'd0, brake_level}, 16'h0001);
        brk_pin = 2'b00;
        idle(12);
        check("R7 release filtered", {15'd0, brake_level}, 16'h0000);
        brk_pin = 2'b10;
        idle(12);
        check("R11 pin1 disabled", {15'd0, brake_level}, 16'h0000);
        brk_pin = 2'b00;

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule